// File: doc/BRIEF.md
# Fixed-Stride Decision Tree Classifier

This block classifies a packet by walking a decision tree held in an on-chip node memory. The search key is the 104-bit flow tuple: two 32-bit addresses, two 16-bit ports and an 8-bit protocol. At every internal node the walker takes one 8-bit slice of the key, chosen by the node itself. That slice picks one of 256 equal cuttings of the node's subspace. Because each step uses up exactly one byte, a search never reads more than 13 node headers. Cutting stops only when a subspace is wholly covered by one rule set, so a leaf carries the action ID directly and no rule scan is needed at the end.

The child pointers are not kept as a full 256-entry table. Adjacent cuttings that share a child are stored once, in a compressed pointer array. Each node header holds a 16-bit aggregation mask in which every bit stands for a group of 16 neighbouring cuttings. The slot in the compressed array is found by counting mask bits. A host port fills the node memory. A lookup is started with a valid/ready handshake, and a one-cycle result pulse returns the action ID, the number of headers read and an error flag.

Node word layout: bit 31 marks a leaf, bits 30..27 select the key byte, and bits 15..0 hold either the aggregation mask (internal node) or the action ID (leaf). An internal node at address A keeps its compressed array base address in word A+1. The root node sits at address 0.

Top module: `fst_lookup`

## Requirements
- R1: After reset, `key_ready` is 1 and `res_valid` is 0.
- R2: When the root header is a leaf (bit 31 = 1), the result carries action = header bits 15..0, depth = 1 and error = 0.
- R3: An internal node with selector value s (bits 30..27) cuts on key bits [103-8s -: 8], so s = 0 selects bits 103..96. All other key bytes have no effect at that node.
- R4: For a selected byte b, let g = b[7:4]. The child pointer is read from base + popcount(mask bits 1..g). The low nibble of b has no effect.
- R5: Mask bit 0 is ignored, because the first group always starts entry 0 of the compressed array.
- R6: `res_depth` equals the number of node headers read, including the leaf. A leaf reached as the 13th header is a valid result.
- R7: `res_valid` rises 3*D-1 clock cycles after the edge that accepts the key, where D is the reported depth.
- R8: If the 13th header read is not a leaf, the result has error = 1, depth = 13 and action = 0.
- R9: An internal header whose selector is 13 or more ends the walk at once, with error = 1, action = 0 and depth = that header's level.
- R10: `key_ready` is 0 from the accepting edge until the edge after the single-cycle `res_valid` pulse. `key_valid` has no effect during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_valid | input | 1 | Lookup request |
| key_in | input | 104 | Search key, protocol byte lowest |
| key_ready | output | 1 | Walker idle, request is taken |
| host_we | input | 1 | Node memory write strobe |
| host_addr | input | 10 | Node memory write address |
| host_wdata | input | 32 | Node memory write data |
| res_valid | output | 1 | One-cycle result pulse |
| res_action | output | 16 | Action ID of the leaf reached |
| res_depth | output | 4 | Node headers read |
| res_err | output | 1 | Walk ended without a valid leaf |

## Verification
A wrong slot count or a wrong byte choice sends the walk to a different child. This shows as a wrong action ID in the same result pulse, so the test trees are built to give every compressed slot its own distinct action. A walker state that skips or repeats a memory read shows as a depth value or a result latency that departs from 3*D-1. That deviation appears on the first lookup that crosses the faulty node. Depth-limit and selector faults are made visible by long and bad-selector chains, where they set the error flag at an exact, predictable cycle.

// File: rtl/fst_pkg.sv
package fst_pkg;
  // Node header field positions: the walker decodes these from memory words.
  localparam int HDR_LEAF   = 31;
  localparam int HDR_SEL_HI = 30;
  localparam int HDR_SEL_LO = 27;
  localparam int HDR_LOW_W  = 16;
  localparam int SEL_W      = HDR_SEL_HI - HDR_SEL_LO + 1;

  typedef enum logic [2:0] {
    W_IDLE, W_HDR, W_BASE, W_PTR, W_HOP, W_DONE
  } walk_state_e;
endpackage

// File: rtl/fst_node_ram.sv
module fst_node_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/fst_cut_index.sv
module fst_cut_index #(
  parameter int KEY_W  = 104,
  parameter int STRIDE = 8,
  parameter int ADDR_W = 10,
  parameter int AGG_W  = 16,
  parameter int SEL_W  = 4
) (
  input  logic [KEY_W-1:0]  key,
  input  logic [SEL_W-1:0]  sel,
  input  logic [AGG_W-1:0]  agg,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] child_addr
);
  localparam int MAX_LVL = KEY_W / STRIDE;
  localparam int GRP_W   = $clog2(AGG_W);
  localparam int OFF_W   = $clog2(AGG_W) + 1;

  // Slice of the key consumed at a node with selector s.
  function automatic logic [STRIDE-1:0] pick_byte(input logic [KEY_W-1:0] k,
                                                 input logic [SEL_W-1:0] s);
    logic [STRIDE-1:0] b;
    b = '0;
    for (int i = 0; i < MAX_LVL; i++)
      if (s == SEL_W'(i)) b = k[KEY_W-1-STRIDE*i -: STRIDE];
    return b;
  endfunction

  // Compressed slot = number of group-start bits from 1 up to grp.
  function automatic logic [OFF_W-1:0] slot_of(input logic [AGG_W-1:0] m,
                                              input logic [GRP_W-1:0] grp);
    logic [OFF_W-1:0] n;
    n = '0;
    for (int i = 1; i < AGG_W; i++)
      if (i <= int'(grp) && m[i]) n = n + OFF_W'(1);
    return n;
  endfunction

  logic [STRIDE-1:0] cut_byte;
  logic [GRP_W-1:0]  cut_grp;
  logic [OFF_W-1:0]  cut_slot;

  always_comb begin
    cut_byte   = pick_byte(key, sel);
    cut_grp    = cut_byte[STRIDE-1 -: GRP_W];
    cut_slot   = slot_of(agg, cut_grp);
    child_addr = base + ADDR_W'(cut_slot);
  end
endmodule

// File: rtl/fst_walk.sv
module fst_walk
  import fst_pkg::*;
#(
  parameter int KEY_W     = 104,
  parameter int STRIDE    = 8,
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int AGG_W     = 16,
  parameter int ACT_W     = 16,
  parameter int ROOT_ADDR = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                key_valid,
  input  logic [KEY_W-1:0]    key_in,
  output logic                key_ready,
  output logic [ADDR_W-1:0]   rd_addr,
  input  logic [DATA_W-1:0]   rd_data,
  output logic                res_valid,
  output logic [ACT_W-1:0]    res_action,
  output logic [$clog2(KEY_W/STRIDE+1)-1:0] res_depth,
  output logic                res_err,
  output logic                ev_leaf,
  output logic                ev_hop,
  output logic [$clog2(KEY_W/STRIDE+1)-1:0] ev_lvl,
  output logic [KEY_W-1:0]    ev_key
);
  localparam int MAX_LVL = KEY_W / STRIDE;
  localparam int LVL_W   = $clog2(MAX_LVL + 1);

  walk_state_e       st_q, st_n;
  logic [KEY_W-1:0]  key_q;
  logic [ADDR_W-1:0] node_q;
  logic [DATA_W-1:0] hdr_q;
  logic [LVL_W-1:0]  lvl_q, lvl_inc;
  logic [ACT_W-1:0]  act_q;
  logic [LVL_W-1:0]  dep_q;
  logic              err_q;
  logic [ADDR_W-1:0] child_addr;

  logic hdr_leaf, sel_bad, at_limit;

  always_comb begin
    hdr_leaf = rd_data[HDR_LEAF];
    sel_bad  = int'(rd_data[HDR_SEL_HI:HDR_SEL_LO]) >= MAX_LVL;
    lvl_inc  = lvl_q + LVL_W'(1);
    at_limit = lvl_inc == LVL_W'(MAX_LVL);
  end

  fst_cut_index #(
    .KEY_W (KEY_W), .STRIDE(STRIDE), .ADDR_W(ADDR_W),
    .AGG_W (AGG_W), .SEL_W (SEL_W)
  ) u_cut (
    .key       (key_q),
    .sel       (hdr_q[HDR_SEL_HI:HDR_SEL_LO]),
    .agg       (hdr_q[AGG_W-1:0]),
    .base      (rd_data[ADDR_W-1:0]),
    .child_addr(child_addr)
  );

  always_comb begin
    st_n    = st_q;
    rd_addr = node_q;
    unique case (st_q)
      W_IDLE: if (key_valid) st_n = W_HDR;
      W_HDR:  st_n = W_BASE;
      W_BASE: begin
        rd_addr = node_q + ADDR_W'(1);
        st_n    = (hdr_leaf || sel_bad || at_limit) ? W_DONE : W_PTR;
      end
      W_PTR: begin
        rd_addr = child_addr;
        st_n    = W_HOP;
      end
      W_HOP: begin
        rd_addr = rd_data[ADDR_W-1:0];
        st_n    = W_BASE;
      end
      W_DONE: st_n = W_IDLE;
      default: st_n = W_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= W_IDLE;
      key_q  <= '0;
      node_q <= ADDR_W'(ROOT_ADDR);
      hdr_q  <= '0;
      lvl_q  <= '0;
      act_q  <= '0;
      dep_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q <= st_n;
      unique case (st_q)
        W_IDLE: if (key_valid) begin
          key_q  <= key_in;
          node_q <= ADDR_W'(ROOT_ADDR);
          lvl_q  <= '0;
        end
        W_BASE: begin
          hdr_q <= rd_data;
          lvl_q <= lvl_inc;
          if (hdr_leaf) begin
            act_q <= rd_data[ACT_W-1:0];
            err_q <= 1'b0;
            dep_q <= lvl_inc;
          end else if (sel_bad || at_limit) begin
            act_q <= '0;
            err_q <= 1'b1;
            dep_q <= lvl_inc;
          end
        end
        W_HOP: node_q <= rd_data[ADDR_W-1:0];
        default: ;
      endcase
    end
  end

  assign key_ready  = (st_q == W_IDLE);
  assign res_valid  = (st_q == W_DONE);
  assign res_action = act_q;
  assign res_depth  = dep_q;
  assign res_err    = err_q;
  assign ev_leaf    = (st_q == W_BASE) && hdr_leaf;
  assign ev_hop     = (st_q == W_HOP);
  assign ev_lvl     = lvl_q;
  assign ev_key     = key_q;
endmodule

// File: rtl/fst_lookup.sv
module fst_lookup #(
  parameter int KEY_W     = 104,
  parameter int STRIDE    = 8,
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int AGG_W     = 16,
  parameter int ACT_W     = 16,
  parameter int ROOT_ADDR = 0,
  localparam int LVL_W    = $clog2(KEY_W/STRIDE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_valid,
  input  logic [KEY_W-1:0]  key_in,
  output logic              key_ready,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              res_valid,
  output logic [ACT_W-1:0]  res_action,
  output logic [LVL_W-1:0]  res_depth,
  output logic              res_err
);
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              ev_leaf, ev_hop;
  logic [LVL_W-1:0]  ev_lvl;
  logic [KEY_W-1:0]  ev_key;

  fst_node_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk    (clk),
    .wr_en  (host_we),
    .wr_addr(host_addr),
    .wr_data(host_wdata),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  fst_walk #(
    .KEY_W(KEY_W), .STRIDE(STRIDE), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .AGG_W(AGG_W), .ACT_W(ACT_W), .ROOT_ADDR(ROOT_ADDR)
  ) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_valid (key_valid),
    .key_in    (key_in),
    .key_ready (key_ready),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .res_valid (res_valid),
    .res_action(res_action),
    .res_depth (res_depth),
    .res_err   (res_err),
    .ev_leaf   (ev_leaf),
    .ev_hop    (ev_hop),
    .ev_lvl    (ev_lvl),
    .ev_key    (ev_key)
  );
endmodule

// File: rtl/fst_lookup_chk.sv
module fst_lookup_chk #(
  parameter int KEY_W  = 104,
  parameter int STRIDE = 8,
  parameter int ACT_W  = 16,
  localparam int MAX_LVL = KEY_W / STRIDE,
  localparam int LVL_W   = $clog2(MAX_LVL + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             key_valid,
  input logic             key_ready,
  input logic             res_valid,
  input logic [ACT_W-1:0] res_action,
  input logic [LVL_W-1:0] res_depth,
  input logic             res_err,
  input logic             ev_leaf,
  input logic             ev_hop,
  input logic [LVL_W-1:0] ev_lvl,
  input logic [KEY_W-1:0] ev_key
);
  assert_result_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !key_ready);

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && key_ready) |=> !key_ready);

  assert_err_zero_action_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_err) |-> (res_action == '0));

  assert_depth_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_depth != '0 && res_depth <= LVL_W'(MAX_LVL)));

  assert_leaf_ends_walk_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_leaf |=> (res_valid && !res_err));

  assert_hop_below_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hop |-> (ev_lvl < LVL_W'(MAX_LVL)));

  assert_key_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!key_ready && $past(!key_ready)) |-> $stable(ev_key));
endmodule

bind fst_lookup fst_lookup_chk #(.KEY_W(KEY_W), .STRIDE(STRIDE), .ACT_W(ACT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .key_valid (key_valid),
  .key_ready (key_ready),
  .res_valid (res_valid),
  .res_action(res_action),
  .res_depth (res_depth),
  .res_err   (res_err),
  .ev_leaf   (ev_leaf),
  .ev_hop    (ev_hop),
  .ev_lvl    (ev_lvl),
  .ev_key    (ev_key)
);

// File: tb/fst_lookup_bench.sv
module fst_lookup_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         key_valid = 1'b0;
  logic [103:0] key_in = '0;
  logic         key_ready;
  logic         host_we = 1'b0;
  logic [9:0]   host_addr = '0;
  logic [31:0]  host_wdata = '0;
  logic         res_valid;
  logic [15:0]  res_action;
  logic [3:0]   res_depth;
  logic         res_err;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  fst_lookup u_fst_lookup (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_in(key_in),
    .key_ready(key_ready), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .res_valid(res_valid), .res_action(res_action),
    .res_depth(res_depth), .res_err(res_err)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = 10'(a); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  function automatic logic [31:0] leaf(input logic [15:0] act);
    return {1'b1, 15'h0, act};
  endfunction

  function automatic logic [31:0] inode(input logic [3:0] sel, input logic [15:0] m);
    return {1'b0, sel, 11'h0, m};
  endfunction

  // Expected slot: mask bits 1..g where g is the byte's upper nibble.
  function automatic int exp_slot(input logic [15:0] m, input logic [7:0] b);
    logic [16:0] keep;
    keep = (17'h1 << (b[7:4] + 1)) - 17'h1;
    return $countones(m & keep[15:0] & 16'hFFFE);
  endfunction

  task automatic lookup(input logic [103:0] k, output logic [15:0] act,
                        output int dep, output bit err, output int lat);
    int cnt = 0;
    @(negedge clk);
    key_valid = 1'b1; key_in = k;
    @(posedge clk);
    @(negedge clk);
    key_valid = 1'b0;
    forever begin
      @(posedge clk); cnt++;
      @(negedge clk);
      if (res_valid || cnt > 200) break;
    end
    act = res_action; dep = int'(res_depth); err = res_err; lat = cnt;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(key_ready === 1'b1, "R1 key_ready", key_ready, 1);
    check(res_valid === 1'b0, "R1 res_valid", res_valid, 0);
  endtask

  task automatic t_root_leaf;
    logic [15:0] a; int d; bit e; int l;
    wr(0, leaf(16'h1234));
    lookup(104'h5A, a, d, e, l);
    check(a == 16'h1234, "R2 action", a, 16'h1234);
    check(d == 1 && !e, "R2 depth/err", d, 1);
    check(l == 2, "R7 latency depth1", l, 2);
  endtask

  task automatic build_one_level(input logic [3:0] sel, input logic [15:0] m);
    wr(0, inode(sel, m)); wr(1, 100);
    for (int i = 0; i < 4; i++) begin
      wr(100 + i, 200 + 10 * i);
      wr(200 + 10 * i, leaf(16'hC000 + 16'(i)));
    end
  endtask

  task automatic t_offsets;
    logic [7:0] vals [8] = '{8'h00, 8'h0F, 8'h4F, 8'h50, 8'h9A, 8'hA0, 8'hF7, 8'hFF};
    logic [15:0] a; int d; bit e; int l;
    build_one_level(4'd0, 16'h8421);
    foreach (vals[i]) begin
      lookup({vals[i], 96'hDEAD_BEEF_0123_4567_89AB_CDEF}, a, d, e, l);
      check(a == 16'hC000 + 16'(exp_slot(16'h8421, vals[i])), "R4 slot action",
            a, 16'hC000 + exp_slot(16'h8421, vals[i]));
    end
    check(d == 2 && l == 5, "R7 latency depth2", l, 5);
  endtask

  task automatic t_selector;
    logic [103:0] k; logic [15:0] a; int d; bit e; int l;
    build_one_level(4'd5, 16'h8421);
    k = '0; k[103:96] = 8'hFF; k[63:56] = 8'h00;
    lookup(k, a, d, e, l);
    check(a == 16'hC000, "R3 byte 5 selected (low)", a, 16'hC000);
    k[63:56] = 8'hB3;
    lookup(k, a, d, e, l);
    check(a == 16'hC002, "R3 byte 5 selected (high)", a, 16'hC002);
  endtask

  task automatic t_bit0;
    logic [15:0] a; int d; bit e; int l;
    build_one_level(4'd0, 16'h8420);
    lookup({8'h5C, 96'h0}, a, d, e, l);
    check(a == 16'hC001, "R5 mask bit0 ignored", a, 16'hC001);
    lookup({8'h03, 96'h0}, a, d, e, l);
    check(a == 16'hC000, "R5 mask bit0 ignored g0", a, 16'hC000);
  endtask

  task automatic build_chain;
    for (int lv = 0; lv < 13; lv++) begin
      wr(8 * lv, inode(4'(lv), 16'h0003));
      wr(8 * lv + 1, 8 * lv + 2);
      wr(8 * lv + 2, 8 * (lv + 1));
      wr(8 * lv + 3, 600 + lv);
      wr(600 + lv, leaf(16'hA000 + 16'(lv)));
    end
  endtask

  task automatic t_chain;
    logic [103:0] k; logic [15:0] a; int d; bit e; int l;
    build_chain();
    k = '0; k[103-8*4 -: 8] = 8'h20;
    lookup(k, a, d, e, l);
    check(a == 16'hA004 && !e, "R6 leaf at depth 6 action", a, 16'hA004);
    check(d == 6, "R6 depth 6", d, 6);
    check(l == 17, "R7 latency depth6", l, 17);
    k = '0; k[103-8*11 -: 8] = 8'h10;
    lookup(k, a, d, e, l);
    check(a == 16'hA00B && !e && d == 13, "R6 leaf as 13th header", a, 16'hA00B);
    lookup(104'h0, a, d, e, l);
    check(e && d == 13 && a == 16'h0, "R8 limit error", {e, 4'(d), a}, {1'b1, 4'd13, 16'h0});
    check(l == 38, "R8 limit latency", l, 38);
  endtask

  task automatic t_bad_sel;
    logic [15:0] a; int d; bit e; int l;
    wr(8, inode(4'd13, 16'h0003));
    lookup(104'h0, a, d, e, l);
    check(e && d == 2 && a == 0, "R9 bad selector level 2", {e, 4'(d), a}, {1'b1, 4'd2, 16'h0});
    check(l == 5, "R9 bad selector latency", l, 5);
    wr(0, inode(4'd15, 16'h0003));
    lookup(104'h0, a, d, e, l);
    check(e && d == 1, "R9 bad selector root", d, 1);
  endtask

  task automatic t_busy;
    logic [103:0] k; bit lo_ok = 1'b1; int pulses = 0; int cnt = 0;
    build_chain();
    k = '0; k[103-8*4 -: 8] = 8'h20;
    @(negedge clk); key_valid = 1'b1; key_in = k;
    @(posedge clk);
    @(negedge clk); key_in = 104'h0;   // held request with another key
    forever begin
      if (key_ready) lo_ok = 1'b0;
      if (res_valid) begin pulses++; break; end
      @(posedge clk); cnt++; @(negedge clk);
      if (cnt > 200) break;
    end
    key_valid = 1'b0;
    check(res_action == 16'hA004, "R10 busy request ignored", res_action, 16'hA004);
    check(lo_ok, "R10 key_ready low while busy", lo_ok, 1);
    @(posedge clk); @(negedge clk);
    check(!res_valid && key_ready, "R10 single pulse then ready", {res_valid, key_ready}, 2'b01);
    check(pulses == 1, "R10 one result", pulses, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_root_leaf();
    t_offsets();
    t_selector();
    t_bit0();
    t_chain();
    t_busy();
    t_bad_sel();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule